// File: doc/BRIEF.md
# Indexed Colour Palette for a 10-bit Video DAC

This block is a colour lookup table placed between an 8-bit indexed pixel stream and a video DAC that takes 10 bits per channel. It holds 256 entries. Each entry is a 30-bit word with three 10-bit channels: blue in the top field, green in the middle and red in the bottom.

A host programs an entry in two steps. It first loads an entry number into an index register, then writes the packed colour word through a data strobe. Reading the data side returns the entry at the current index. On the video side, a pixel arrives with a valid strobe, and the looked-up colour leaves one clock later. In overlay mode the pixel is masked to its low seven bits before the lookup, so values of 0x80 and above land back in the lower half of the table.

A separate combinational helper turns three 8-bit colour components into a packed 30-bit word, which host software can then write to the table. It widens each component by appending the component's top two bits below it. It can also complement the components first, which gives the colour for the inverse slot at index 0x7F XOR n.

Top module: `clut_palette`

## Requirements
- R1: The table has 256 entries of 30 bits. Each entry is laid out as blue[29:20], green[19:10], red[9:0], and a lookup returns exactly the last word written to that entry.
- R2: A pulse on `host_idx_we` loads `host_wdata[7:0]` into the index register. A pulse on `host_data_we` stores all 30 bits of `host_wdata` into the entry that the index register selects.
- R3: Data writes never change the index, so repeated data writes all go to the same entry. When the index strobe and the data strobe occur in the same cycle, the data goes to the old index and the index then takes the new value.
- R4: A pixel sampled with `pix_valid` high at clock edge k appears on `out_rgb`, with `out_valid` high, after edge k. In a cycle with no valid pixel, `out_valid` is low on the next cycle and `out_rgb` holds its last value.
- R5: With `ovl_mode` high, the lookup uses `pix_in & 0x7F`. With it low, the lookup uses all 8 bits.
- R6: When a host write and a lookup touch the same entry in the same cycle, the lookup returns the old word. A later lookup returns the new word.
- R7: `host_rdata` is registered. One cycle after an edge, it shows the entry at the index as it stood before that edge.
- R8: After reset every entry reads as zero, and the index, `out_valid`, `out_rgb` and `host_rdata` are all zero.
- R9: The helper maps each 8-bit component c to the 10-bit value {c, c[7:6]}, so 0x00 becomes 0x000 and 0xFF becomes 0x3FF. It packs the three results in the R1 layout without any clock delay.
- R10: With `exp_invert` high, the helper complements each component before widening it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_idx_we | input | 1 | Load the index register from `host_wdata[7:0]` |
| host_data_we | input | 1 | Write `host_wdata` into the indexed entry |
| host_wdata | input | 30 | Host write word |
| host_rdata | output | 30 | Entry at the current index, registered |
| pix_valid | input | 1 | Pixel strobe |
| pix_in | input | 8 | Pixel index |
| ovl_mode | input | 1 | Mask the pixel to 7 bits before the lookup |
| out_valid | output | 1 | Colour output valid |
| out_rgb | output | 30 | Looked-up colour |
| exp_r | input | 8 | Helper red component |
| exp_g | input | 8 | Helper green component |
| exp_b | input | 8 | Helper blue component |
| exp_invert | input | 1 | Complement the components before widening |
| exp_word | output | 30 | Packed widened colour |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 10-bit channels and a 7-bit overlay mask. This size makes every entry reachable. Each of the 256 pixel values is looked up in both modes, so the aliasing of the upper half of the table under overlay mode is checked across the whole table. All 256 component values are swept through the helper in both polarities.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int NUM_CH = 3;
endpackage

// File: rtl/clut_widen.sv
module clut_widen #(
  parameter int COMP_W = 8,
  parameter int CH_W   = 10
) (
  input  logic [clut_pkg::NUM_CH*COMP_W-1:0] comps,
  input  logic                               invert,
  output logic [clut_pkg::NUM_CH*CH_W-1:0]   word
);
  localparam int EXT = CH_W - COMP_W;

  for (genvar k = 0; k < clut_pkg::NUM_CH; k++) begin : g_ch
    logic [COMP_W-1:0] c;
    assign c = invert ? ~comps[k*COMP_W +: COMP_W] : comps[k*COMP_W +: COMP_W];
    assign word[k*CH_W +: CH_W] = {c, c[COMP_W-1 -: EXT]};
  end
endmodule

// File: rtl/clut_host_regs.sv
module clut_host_regs #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_we) idx_q <= wdata[IDX_W-1:0];
  end

  // a data write always uses the index held before this edge
  assign wr_en   = data_we;
  assign wr_addr = idx_q;
  assign wr_data = wdata;

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !idx_we |=> $stable(idx_q));
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pa_en,
  input  logic [IDX_W-1:0]  pa_addr,
  output logic [WORD_W-1:0] pa_data,
  input  logic [IDX_W-1:0]  hb_addr,
  output logic [WORD_W-1:0] hb_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  live;
  logic [WORD_W-1:0] pa_raw, hb_raw;
  logic              pa_live, hb_live;

  // memory array without reset, suited to block RAM inference
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (pa_en) pa_raw <= mem[pa_addr];
    hb_raw <= mem[hb_addr];
  end

  // per-entry written flags give the all-zero state after reset in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      pa_live <= 1'b0;
      hb_live <= 1'b0;
    end else begin
      if (wr_en) live[wr_addr] <= 1'b1;
      if (pa_en) pa_live <= live[pa_addr];
      hb_live <= live[hb_addr];
    end
  end

  assign pa_data = pa_live ? pa_raw : '0;
  assign hb_data = hb_live ? hb_raw : '0;

  // R1
  live_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> live[$past(wr_addr)]);

  // R8
  live_clear_chk: assert property (@(posedge clk)
    rst |=> (live == '0));
endmodule

// File: rtl/clut_pix_stage.sv
module clut_pix_stage #(
  parameter int IDX_W = 8,
  parameter int OVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_in,
  input  logic             ovl_mode,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             out_valid
);
  localparam logic [IDX_W-1:0] OVL_MASK = IDX_W'((1 << OVL_W) - 1);

  assign rd_en   = pix_valid;
  assign rd_addr = ovl_mode ? (pix_in & OVL_MASK) : pix_in;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= pix_valid;
  end

  // R4
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);

  // R4
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);
endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
  parameter int IDX_W  = 8,
  parameter int CH_W   = 10,
  parameter int COMP_W = 8,
  parameter int OVL_W  = 7
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               host_idx_we,
  input  logic                               host_data_we,
  input  logic [clut_pkg::NUM_CH*CH_W-1:0]   host_wdata,
  output logic [clut_pkg::NUM_CH*CH_W-1:0]   host_rdata,
  input  logic                               pix_valid,
  input  logic [IDX_W-1:0]                   pix_in,
  input  logic                               ovl_mode,
  output logic                               out_valid,
  output logic [clut_pkg::NUM_CH*CH_W-1:0]   out_rgb,
  input  logic [COMP_W-1:0]                  exp_r,
  input  logic [COMP_W-1:0]                  exp_g,
  input  logic [COMP_W-1:0]                  exp_b,
  input  logic                               exp_invert,
  output logic [clut_pkg::NUM_CH*CH_W-1:0]   exp_word
);
  localparam int WORD_W = clut_pkg::NUM_CH * CH_W;

  logic [IDX_W-1:0]  idx_q, wr_addr, rd_addr;
  logic              wr_en, rd_en;
  logic [WORD_W-1:0] wr_data;

  clut_host_regs #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_host (
    .clk(clk), .rst(rst), .idx_we(host_idx_we), .data_we(host_data_we),
    .wdata(host_wdata), .idx_q(idx_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  clut_pix_stage #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_pix (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_in(pix_in),
    .ovl_mode(ovl_mode), .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(out_valid)
  );

  clut_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pa_en(rd_en), .pa_addr(rd_addr), .pa_data(out_rgb),
    .hb_addr(idx_q), .hb_data(host_rdata)
  );

  clut_widen #(.COMP_W(COMP_W), .CH_W(CH_W)) u_widen (
    .comps({exp_b, exp_g, exp_r}), .invert(exp_invert), .word(exp_word)
  );

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(out_rgb));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_rgb == '0 && host_rdata == '0));
endmodule

// File: tb/clut_palette_bench.sv
`timescale 1ns/1ps
module clut_palette_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_idx_we = 1'b0, host_data_we = 1'b0;
  logic [29:0] host_wdata = '0;
  logic [29:0] host_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_in = '0;
  logic        ovl_mode = 1'b0;
  logic        out_valid;
  logic [29:0] out_rgb;
  logic [7:0]  exp_r = '0, exp_g = '0, exp_b = '0;
  logic        exp_invert = 1'b0;
  logic [29:0] exp_word;

  int checks = 0;
  int errors = 0;
  logic [29:0] model [256];
  logic [29:0] last_out;

  always #5 clk = ~clk;

  clut_palette u_clut_palette (
    .clk(clk), .rst(rst), .host_idx_we(host_idx_we), .host_data_we(host_data_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pix_valid(pix_valid),
    .pix_in(pix_in), .ovl_mode(ovl_mode), .out_valid(out_valid), .out_rgb(out_rgb),
    .exp_r(exp_r), .exp_g(exp_g), .exp_b(exp_b), .exp_invert(exp_invert),
    .exp_word(exp_word)
  );

  function automatic logic [29:0] pat(input int i, input int salt);
    logic [9:0] r, g, b;
    r = 10'((i * 11 + salt) & 1023);
    g = 10'((i ^ 'h2A5 ^ salt) & 1023);
    b = 10'((1023 - i * 3 - salt) & 1023);
    return {b, g, r};
  endfunction

  function automatic logic [9:0] widen(input int c);
    return 10'(c * 4 + c / 64);
  endfunction

  task automatic chk(input string req, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_idx(input int i);
    @(negedge clk); host_idx_we = 1'b1; host_wdata = 30'(i);
    @(negedge clk); host_idx_we = 1'b0;
  endtask

  task automatic put_data(input int i, input logic [29:0] v);
    @(negedge clk); host_data_we = 1'b1; host_wdata = v;
    @(negedge clk); host_data_we = 1'b0;
    model[i] = v;
  endtask

  task automatic look(input string req, input int p, input logic m, input logic [29:0] exp);
    @(negedge clk); pix_valid = 1'b1; pix_in = 8'(p); ovl_mode = m;
    @(negedge clk); pix_valid = 1'b0;
    chk(req, {29'b0, out_valid}, 30'd1);
    chk(req, out_rgb, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state at the ports
    chk("R8", {29'b0, out_valid}, 30'd0);
    chk("R8", out_rgb, 30'd0);
    chk("R8", host_rdata, 30'd0);
    for (int i = 0; i < 256; i++) begin
      model[i] = '0;
      look("R8", i, 1'b0, 30'd0);
    end

    // R1 R2: fill every entry
    for (int i = 0; i < 256; i++) begin
      put_idx(i);
      put_data(i, pat(i, 0));
    end
    for (int i = 0; i < 256; i++) look("R1", i, 1'b0, model[i]);
    // R5: overlay masking aliases the upper half onto the lower half
    for (int i = 0; i < 256; i++) look("R5", i, 1'b1, model[i & 'h7F]);

    // R7: host read-back of the indexed entry
    for (int i = 0; i < 256; i += 17) begin
      put_idx(i);
      @(negedge clk);
      chk("R7", host_rdata, model[i]);
    end

    // R3: no auto-increment, repeated data writes hit the same entry
    put_idx(10);
    put_data(10, 30'h1234567);
    put_data(10, 30'h2ABCDEF);
    look("R3", 10, 1'b0, 30'h2ABCDEF);
    look("R3", 11, 1'b0, model[11]);
    chk("R3", host_rdata, 30'h2ABCDEF);

    // R3: index and data strobes together; data goes to the old index
    @(negedge clk);
    host_idx_we = 1'b1; host_data_we = 1'b1; host_wdata = 30'h0555514;
    @(negedge clk);
    host_idx_we = 1'b0; host_data_we = 1'b0;
    model[10] = 30'h0555514;
    @(negedge clk);
    chk("R3", host_rdata, model[20]);
    look("R3", 10, 1'b0, model[10]);
    look("R3", 20, 1'b0, model[20]);

    // R6: same-cycle write and lookup of one entry
    put_idx(5);
    @(negedge clk);
    host_data_we = 1'b1; host_wdata = 30'h3FFFFFF;
    pix_valid = 1'b1; pix_in = 8'd5; ovl_mode = 1'b0;
    @(negedge clk);
    host_data_we = 1'b0; pix_valid = 1'b0;
    chk("R6", out_rgb, model[5]);
    model[5] = 30'h3FFFFFF;
    look("R6", 5, 1'b0, model[5]);

    // R4: out_rgb holds and out_valid drops while no pixel is valid
    last_out = out_rgb;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R4", {29'b0, out_valid}, 30'd0);
      chk("R4", out_rgb, last_out);
    end

    // R9 R10: widening helper, full component sweep
    for (int c = 0; c < 256; c++) begin
      exp_invert = 1'b0;
      exp_r = 8'(c); exp_g = 8'(255 - c); exp_b = 8'(c ^ 'h5A);
      #1;
      chk("R9", exp_word, {widen(c ^ 'h5A), widen(255 - c), widen(c)});
      exp_invert = 1'b1;
      #1;
      chk("R10", exp_word, {widen(255 - (c ^ 'h5A)), widen(c), widen(255 - c)});
    end
    exp_invert = 1'b0; exp_r = 8'hFF; exp_g = 8'h00; exp_b = 8'h80;
    #1;
    chk("R9", exp_word, {10'h202, 10'h000, 10'h3FF});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule